// File: doc/BRIEF.md
# Dual-Channel Converter Output Mode Controller

This block sits behind the two conversion channels of a dual converter, one called I and one called Q. Each channel supplies a new data word on every rising edge of its own clock. The block decides, per channel, whether that word reaches the output bus. It also raises a per-channel flag once the output data can be trusted.

A two-bit mode input chooses one of four operating modes. Both channels can idle, only I can run, both can run in phase, or both can run with the Q bus shifted by half a clock period. The mode input has no timing relation to either channel clock, so each channel resynchronizes it in its own clock domain before decoding it. An idle channel freezes its bus at the last word it presented and always drives it. It never floats the bus.

A channel that starts running, either after reset or on leaving idle, keeps its valid flag low for a fixed recovery count of clocks.

Top module: `dual_adc_outmode`

## Requirements
- R1: Mode encoding on `mode_sel[1:0]`: 2'b00 idles both channels; 2'b01 runs I and idles Q; 2'b10 runs both channels with aligned output; 2'b11 runs both channels and shifts the Q output by half a clock.
- R2: While `rst_n` is low, both output words are all zero and both valid flags are low. The reset takes effect without a clock edge, and the decoded mode it leaves behind idles both channels.
- R3: Each channel passes `mode_sel` through SYNC_STAGES (default 2) flops clocked by its own clock. A mode value present at rising edge k first governs that channel at rising edge k+SYNC_STAGES.
- R4: At every rising edge that a running mode governs, a channel loads its input word into its output register. The output shows that word until the next edge.
- R5: At a rising edge governed by a mode that idles the channel, the output word keeps its previous value. It is never unknown or high impedance.
- R6: The valid flag of a channel is high exactly when the channel runs and has run for at least RECOVER_CYCLES (default 20) consecutive governed rising edges. It rises right after the 20th such edge.
- R7: The valid flag falls right after the first edge whose governing mode idles the channel, before that edge's capture would occur.
- R8: Every return from idle to running restarts the recovery count from zero, so the full RECOVER_CYCLES wait applies again.
- R9: Switching between modes 2'b10 and 2'b11 does not idle the Q channel. It neither restarts the recovery count nor freezes the Q output.
- R10: While the Q channel's governing mode is 2'b11, `q_word_out` shows the Q output register value captured at the most recent falling edge of `q_clk`. In every other mode, `q_word_out` shows that register directly.
- R11: The I output is never shifted. In every mode it follows R4 and R5 on rising edges of `i_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | I channel clock |
| q_clk | input | 1 | Q channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode select, asynchronous to both clocks |
| i_word_in | input | DATA_W | I channel data word from the datapath |
| q_word_in | input | DATA_W | Q channel data word from the datapath |
| i_word_out | output | DATA_W | I channel output bus |
| q_word_out | output | DATA_W | Q channel output bus, optionally half-cycle shifted |
| i_valid | output | 1 | I channel data valid after recovery |
| q_valid | output | 1 | Q channel data valid after recovery |

## Verification
The bench builds the block with its default values: an 8-bit word, a recovery count of 20, two synchronizer stages and the half-cycle Q shift built in. It drives both channel clocks from one source. This lets one cycle model predict the exact edge on which each valid flag rises, and lets the bench check the shifted Q word at both clock phases. With a recovery count of 20, a bench of a few thousand cycles can cover many full recoveries, aborted recoveries and 10/11 switches in the middle of a count. The bench also checks the exact rise point of 22 edges, which is the recovery count plus the synchronizer depth.

// File: rtl/dual_adc_outmode_pkg.sv
package dual_adc_outmode_pkg;

   typedef enum logic [1:0] {
      MODE_SLEEP     = 2'b00,
      MODE_I_ONLY    = 2'b01,
      MODE_PAIR      = 2'b10,
      MODE_PAIR_SKEW = 2'b11
   } opmode_e;

   // Whether a lane is running in a given mode; the Q lane needs the pair modes.
   function automatic logic lane_running(opmode_e m, logic is_q);
      if (is_q) return (m == MODE_PAIR) || (m == MODE_PAIR_SKEW);
      return m != MODE_SLEEP;
   endfunction

endpackage

// File: rtl/adcmode_sync.sv
module adcmode_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= d_async;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/adcmode_recover.sv
module adcmode_recover #(
   parameter int LIMIT = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   localparam int CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (cnt != LIM_C) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign done = run && (cnt == LIM_C);

endmodule

// File: rtl/adcmode_half_align.sv
module adcmode_half_align #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              skew_en,
   input  logic [DATA_W-1:0] word_in,
   output logic [DATA_W-1:0] word_out
);

   logic [DATA_W-1:0] fall_r;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) fall_r <= '0;
      else        fall_r <= word_in;
   end

   assign word_out = skew_en ? fall_r : word_in;

endmodule

// File: rtl/adcmode_lane.sv
module adcmode_lane
   import dual_adc_outmode_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int RECOVER_CYCLES = 20,
   parameter int SYNC_STAGES    = 2,
   parameter bit IS_Q           = 1'b0,
   parameter bit HALF_DELAY_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_async,
   input  logic [DATA_W-1:0] word_in,
   output logic [DATA_W-1:0] word_out,
   output logic              valid,
   output logic              active
);

   logic [1:0]        mode_s;
   opmode_e           mode_q;
   logic [DATA_W-1:0] hold_r;

   adcmode_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (mode_async),
      .q_sync  (mode_s)
   );

   assign mode_q = opmode_e'(mode_s);
   assign active = lane_running(mode_q, IS_Q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hold_r <= '0;
      else if (active) hold_r <= word_in;
   end

   adcmode_recover #(.LIMIT(RECOVER_CYCLES)) u_recover (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (active),
      .done  (valid)
   );

   if (IS_Q && HALF_DELAY_EN) begin : g_skew
      adcmode_half_align #(.DATA_W(DATA_W)) u_align (
         .clk      (clk),
         .rst_n    (rst_n),
         .skew_en  (mode_q == MODE_PAIR_SKEW),
         .word_in  (hold_r),
         .word_out (word_out)
      );
   end else begin : g_direct
      assign word_out = hold_r;
   end

endmodule

// File: rtl/dual_adc_outmode.sv
module dual_adc_outmode #(
   parameter int DATA_W         = 8,
   parameter int RECOVER_CYCLES = 20,
   parameter int SYNC_STAGES    = 2,
   parameter bit HALF_DELAY_EN  = 1'b1
) (
   input  logic              i_clk,
   input  logic              q_clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_sel,
   input  logic [DATA_W-1:0] i_word_in,
   input  logic [DATA_W-1:0] q_word_in,
   output logic [DATA_W-1:0] i_word_out,
   output logic [DATA_W-1:0] q_word_out,
   output logic              i_valid,
   output logic              q_valid
);

   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (RECOVER_CYCLES < 1) begin : g_bad_recover
      $error("RECOVER_CYCLES must be at least 1");
   end

   logic i_active;
   logic q_active;

   adcmode_lane #(
      .DATA_W(DATA_W), .RECOVER_CYCLES(RECOVER_CYCLES),
      .SYNC_STAGES(SYNC_STAGES), .IS_Q(1'b0), .HALF_DELAY_EN(HALF_DELAY_EN)
   ) u_lane_i (
      .clk        (i_clk),
      .rst_n      (rst_n),
      .mode_async (mode_sel),
      .word_in    (i_word_in),
      .word_out   (i_word_out),
      .valid      (i_valid),
      .active     (i_active)
   );

   adcmode_lane #(
      .DATA_W(DATA_W), .RECOVER_CYCLES(RECOVER_CYCLES),
      .SYNC_STAGES(SYNC_STAGES), .IS_Q(1'b1), .HALF_DELAY_EN(HALF_DELAY_EN)
   ) u_lane_q (
      .clk        (q_clk),
      .rst_n      (rst_n),
      .mode_async (mode_sel),
      .word_in    (q_word_in),
      .word_out   (q_word_out),
      .valid      (q_valid),
      .active     (q_active)
   );

endmodule

// File: rtl/dual_adc_outmode_chk.sv
module dual_adc_outmode_chk #(
   parameter int DATA_W         = 8,
   parameter int RECOVER_CYCLES = 20
) (
   input logic              i_clk,
   input logic              q_clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] i_word_out,
   input logic [DATA_W-1:0] q_word_out,
   input logic              i_valid,
   input logic              q_valid,
   input logic              i_active,
   input logic              q_active
);

   int unsigned run_i;
   int unsigned run_q;

   always_ff @(posedge i_clk or negedge rst_n) begin
      if (!rst_n)                            run_i <= 0;
      else if (!i_active)                    run_i <= 0;
      else if (run_i < RECOVER_CYCLES)       run_i <= run_i + 1;
   end

   always_ff @(posedge q_clk or negedge rst_n) begin
      if (!rst_n)                            run_q <= 0;
      else if (!q_active)                    run_q <= 0;
      else if (run_q < RECOVER_CYCLES)       run_q <= run_q + 1;
   end

   // R2
   reset_quiet_chk: assert property (@(posedge i_clk)
      !rst_n |-> (!i_valid && !q_valid && i_word_out == '0));

   // R5
   i_idle_hold_chk: assert property (@(posedge i_clk) disable iff (!rst_n)
      !i_active |=> $stable(i_word_out));

   // R5
   q_idle_hold_chk: assert property (@(posedge q_clk) disable iff (!rst_n)
      !q_active |=> $stable(q_word_out));

   // R5
   no_float_chk: assert property (@(posedge i_clk) disable iff (!rst_n)
      !$isunknown(i_word_out) && !$isunknown(q_word_out));

   // R6
   i_recover_chk: assert property (@(posedge i_clk) disable iff (!rst_n)
      i_valid |-> (run_i >= RECOVER_CYCLES));

   // R6
   q_recover_chk: assert property (@(posedge q_clk) disable iff (!rst_n)
      q_valid |-> (run_q >= RECOVER_CYCLES));

   // R7
   i_valid_idle_chk: assert property (@(posedge i_clk) disable iff (!rst_n)
      i_valid |-> i_active);

   // R1
   q_needs_i_chk: assert property (@(posedge i_clk) disable iff (!rst_n)
      q_active |-> i_active);

endmodule

bind dual_adc_outmode dual_adc_outmode_chk #(
   .DATA_W(DATA_W), .RECOVER_CYCLES(RECOVER_CYCLES)
) u_chk (
   .i_clk      (i_clk),
   .q_clk      (q_clk),
   .rst_n      (rst_n),
   .i_word_out (i_word_out),
   .q_word_out (q_word_out),
   .i_valid    (i_valid),
   .q_valid    (q_valid),
   .i_active   (i_active),
   .q_active   (q_active)
);

// File: tb/dual_adc_outmode_tb_top.sv
module dual_adc_outmode_tb_top;

   localparam int DW  = 8;
   localparam int REC = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic [DW-1:0] i_in = '0;
   logic [DW-1:0] q_in = '0;
   logic [DW-1:0] i_out, q_out;
   logic          i_val, q_val;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #10 clk = ~clk;

   dual_adc_outmode #(.DATA_W(DW), .RECOVER_CYCLES(REC)) dut_i (
      .i_clk(clk), .q_clk(clk), .rst_n(rst_n), .mode_sel(mode),
      .i_word_in(i_in), .q_word_in(q_in),
      .i_word_out(i_out), .q_word_out(q_out),
      .i_valid(i_val), .q_valid(q_val)
   );

   // Reference cycle model built from R1..R11
   logic [1:0]    m1, m2;
   logic [DW-1:0] ei, eq, eq_fall;
   int            ci, cq;

   function automatic logic runs(logic [1:0] m, bit is_q);
      return is_q ? m[1] : (m != 2'b00);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m1 <= 2'b00; m2 <= 2'b00; ei <= '0; eq <= '0; ci <= 0; cq <= 0;
      end else begin
         m1 <= mode;
         m2 <= m1;
         if (runs(m2, 1'b0)) ei <= i_in;
         if (runs(m2, 1'b1)) eq <= q_in;
         ci <= runs(m2, 1'b0) ? ((ci < REC) ? ci + 1 : ci) : 0;
         cq <= runs(m2, 1'b1) ? ((cq < REC) ? cq + 1 : cq) : 0;
      end
   end

   always @(negedge clk or negedge rst_n) begin
      if (!rst_n) eq_fall <= '0;
      else        eq_fall <= eq;
   end

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      check("R4 R5 R11 i_word_out", i_out, ei);
      check("R4 R5 R9 R10 q_word_out", q_out, (m2 == 2'b11) ? eq_fall : eq);
      check("R6 R7 R8 i_valid", {7'b0, i_val},
            {7'b0, runs(m2, 1'b0) && ci == REC});
      check("R6 R7 R8 R9 q_valid", {7'b0, q_val},
            {7'b0, runs(m2, 1'b1) && cq == REC});
   endtask

   task automatic step();
      @(posedge clk); #5; check_all();
      @(negedge clk); #5; check_all();
      i_in = DW'($urandom);
      q_in = DW'($urandom);
   endtask

   task automatic run_mode(logic [1:0] m, int n);
      mode = m;
      for (int k = 0; k < n; k++) step();
   endtask

   initial begin
      void'($urandom(32'h5eed_0a1c));
      // R2: reset state
      #25;
      check("R2 i_word_out", i_out, '0);
      check("R2 q_word_out", q_out, '0);
      check("R2 valids", {6'b0, i_val, q_val}, '0);
      @(negedge clk); #5; rst_n = 1'b1;
      run_mode(2'b00, 5);
      // R3 R6: exact rise point after entering mode 10
      begin
         int cnt = 0;
         mode = 2'b10;
         while (!i_val && cnt < 40) begin step(); cnt++; end
         total++;
         if (cnt != REC + 2) begin
            bad++;
            $display("FAIL R3 R6 rise edges actual=%0d expected=%0d", cnt, REC + 2);
         end
      end
      run_mode(2'b10, 5);
      run_mode(2'b11, 30);   // R9 R10 shift without restart
      run_mode(2'b10, 3);    // R9
      run_mode(2'b01, 25);   // R5 Q frozen, I running
      run_mode(2'b11, 10);   // R8 Q restarts, aborted early
      run_mode(2'b00, 8);    // R5 R7 both frozen
      run_mode(2'b11, 30);   // R8 full recovery into shift mode
      // Random mode sequences
      for (int seg = 0; seg < 120; seg++)
         run_mode(2'($urandom), 1 + ($urandom % 35));
      // R2: asynchronous reset mid-run
      @(posedge clk); #3; rst_n = 1'b0; #2;
      check("R2 i_word_out async", i_out, '0);
      check("R2 q_word_out async", q_out, '0);
      check("R2 valids async", {6'b0, i_val, q_val}, '0);
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 190000);
      if (!ended) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule